// File: doc/BRIEF.md
# UART Software Flow-Control Controller

This block sits between a UART channel's transmit FIFO, its serializer and its receive path and adds in-band Xon/Xoff flow control. Every received character is compared against two host-programmable match registers. A match sets a sticky bit in the status byte whether or not any feature is enabled, so the comparator also serves as a general two-pattern character detector. When Xoff recognition is on, a received Xoff stops the transmitter at a character boundary. When Xon recognition is on, a received Xon releases it.

When the auto-receiver mode is on, the host can ask the block to send an Xon or an Xoff. That flow character goes to the serializer ahead of the next FIFO data character, and it is sent even while the transmitter is flow-halted. The status byte reports the last flow characters sent, the transmit flow state and the transmit character state. Reading the status byte clears its event fields. Four feature enables are written as set/clear bit pairs, and a clear in the pair takes precedence over a set.

Host accesses are single-cycle strobes. Read data appears on `reg_rdata` in the cycle after `reg_rd`. Register map: 0 status, 1 enables, 2 mode, 3 Xon match character, 4 Xoff match character, 5 send command.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the enable readback (address 1, bits 3:0) reads 0, the mode reads 0 and the Xon/Xoff match registers hold 0x11 and 0x13.
- R2: A write to address 1 treats bit 2k as a set and bit 2k+1 as a clear for feature k (k=0 watchdog, 1 address recognition, 2 Xon recognition, 3 Xoff recognition). Both bits at 1 clears the feature, and both at 0 leaves it unchanged. Address 1 reads back {Xoff, Xon, address, watchdog} in bits 3:0, and the watchdog and address flags drive `wdog_en` and `addr_rec_en`.
- R3: Status bits 7:6 hold the received-flow-character field: bit 6 is set by a received Xoff match (code 01) and bit 7 by an Xon match (code 10), giving 11 when both have arrived. Matches set the bits whatever the enables and mode say, and the bits stay set until a status read.
- R4: A status read (address 0) returns the byte one cycle later and clears bits 7:4. An event that arrives in the same cycle as the read is kept in the cleared field.
- R5: With Xoff recognition on, a received Xoff moves flow status (bits 3:2) from 00 or 10 to 11 if no character is on the line, or else to 01 until that character's `ser_done`, then to 11. No FIFO character is loaded while the flow status is 01 or 11.
- R6: With Xon recognition on, a received Xon in flow status 01 or 11 moves it to 10 and FIFO data flows again. A status read that returns 10 leaves the flow status at 00.
- R7: With both Xon and Xoff recognition off, the flow status is 00 and received flow characters do not stop the transmitter.
- R8: A write to address 5 requests a send, with bit 0 for Xon and bit 1 for Xoff (bit 1 wins if both are set). Requests are accepted only while mode bit 0 (auto-receiver) is 1. The requested character is loaded before any further FIFO character, even while flow-halted, and only one character is on the line at a time.
- R9: Status bits 5:4 record the flow characters sent: bit 4 for Xon (01), bit 5 for Xoff (10), 11 for both. The field reads 00 while auto-receiver mode is off.
- R10: Status bits 1:0 read 11 while an Xon send is pending and 10 while an Xoff send is pending. They read 01 from the end of a flow character until the next FIFO character is loaded, and 00 otherwise. They are forced to 00 when auto-receiver mode, Xon recognition and Xoff recognition are all off.
- R11: Addresses 3 and 4 are writable and read back. Their values are the patterns matched on receive and the characters sent on request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid the cycle after reg_rd |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| fifo_data | input | 8 | Head of the transmit FIFO |
| fifo_pop | output | 1 | Remove the FIFO head (it is being loaded) |
| ser_load | output | 1 | Hand ser_data to the serializer |
| ser_data | output | 8 | Character handed to the serializer |
| ser_done | input | 1 | Pulse when the serializer finishes a character's stop bit |
| wdog_en | output | 1 | Receiver watchdog enable flag |
| addr_rec_en | output | 1 | Address recognition enable flag |

## Verification
The bench builds the block with its default 8-bit character width and reset match characters 0x11 and 0x13. It pairs the block with a serializer model whose characters occupy 13 clocks, long enough to land a received Xoff or a send request inside a character in flight. That makes the halt-pending state and the pending send codes observable through status reads. It also lets the bench check, from the order of characters on the line, that a flow character overtakes queued FIFO data.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

    typedef enum logic [1:0] {
        FL_NORMAL   = 2'b00,
        FL_HALTPEND = 2'b01,
        FL_REEN     = 2'b10,
        FL_HALTED   = 2'b11
    } flow_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'b00,
        PD_XOFF = 2'b10,
        PD_XON  = 2'b11
    } pend_e;

    localparam logic [2:0] ADR_STAT = 3'd0;
    localparam logic [2:0] ADR_ENAB = 3'd1;
    localparam logic [2:0] ADR_MODE = 3'd2;
    localparam logic [2:0] ADR_XON  = 3'd3;
    localparam logic [2:0] ADR_XOFF = 3'd4;
    localparam logic [2:0] ADR_CMD  = 3'd5;

    localparam int NFEAT   = 4;
    localparam int FT_WDOG = 0;
    localparam int FT_ADDR = 1;
    localparam int FT_XON  = 2;
    localparam int FT_XOFF = 3;

endpackage

// File: rtl/xflow_enable_bank.sv
module xflow_enable_bank #(
    parameter int NF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [2*NF-1:0] pairs,
    output logic [NF-1:0]   en
);
    logic [NF-1:0] en_d, en_q;

    for (genvar k = 0; k < NF; k++) begin : g_feat
        // clear bit dominates the set bit of the same pair
        assign en_d[k] = !wr              ? en_q[k] :
                         pairs[2*k+1]     ? 1'b0    :
                         pairs[2*k]       ? 1'b1    : en_q[k];

        // R2
        clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && pairs[2*k+1]) |=> !en[k]);
        // R2
        set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && pairs[2*k] && !pairs[2*k+1]) |=> en[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;
endmodule

// File: rtl/xflow_match.sv
module xflow_match #(
    parameter int CW = 8
) (
    input  logic          valid,
    input  logic [CW-1:0] data,
    input  logic [CW-1:0] xon_chr,
    input  logic [CW-1:0] xoff_chr,
    output logic          hit_xon,
    output logic          hit_xoff
);
    always_comb begin
        hit_xon  = valid && (data == xon_chr);
        hit_xoff = valid && (data == xoff_chr);
    end
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl
    import xflow_pkg::*;
#(
    parameter int          CHAR_W   = 8,
    parameter logic [7:0]  XON_RST  = 8'h11,
    parameter logic [7:0]  XOFF_RST = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [CHAR_W-1:0] reg_wdata,
    output logic [CHAR_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              ser_load,
    output logic [CHAR_W-1:0] ser_data,
    input  logic              ser_done,
    output logic              wdog_en,
    output logic              addr_rec_en
);
    localparam int PAIR_W = 2 * NFEAT;

    typedef struct packed {
        logic [1:0]        rxx;       // {xon seen, xoff seen}
        logic [1:0]        atx;       // {xoff sent, xon sent}
        flow_e             flow;
        pend_e             pend;
        logic              idle_wait;
        logic              cur_x;
        logic              busy;
        logic              auto_rx;
        logic [CHAR_W-1:0] xon_chr;
        logic [CHAR_W-1:0] xoff_chr;
        logic [CHAR_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [NFEAT-1:0] en;
    logic             hit_xon, hit_xoff;
    logic             rd_stat, wr_enab, wr_mode, wr_xon, wr_xoff, wr_cmd;
    logic             xon_en, xoff_en, flow_ctl_on;
    logic             load_x, load_data, busy_now, data_ok;
    logic [1:0]       charst;
    logic [7:0]       stat;

    xflow_enable_bank #(.NF(NFEAT)) u_enab (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_enab),
        .pairs (reg_wdata[PAIR_W-1:0]),
        .en    (en)
    );

    xflow_match #(.CW(CHAR_W)) u_match (
        .valid    (rx_valid),
        .data     (rx_data),
        .xon_chr  (st_q.xon_chr),
        .xoff_chr (st_q.xoff_chr),
        .hit_xon  (hit_xon),
        .hit_xoff (hit_xoff)
    );

    always_comb begin
        rd_stat = reg_rd && (reg_addr == ADR_STAT);
        wr_enab = reg_wr && (reg_addr == ADR_ENAB);
        wr_mode = reg_wr && (reg_addr == ADR_MODE);
        wr_xon  = reg_wr && (reg_addr == ADR_XON);
        wr_xoff = reg_wr && (reg_addr == ADR_XOFF);
        wr_cmd  = reg_wr && (reg_addr == ADR_CMD);

        xon_en      = en[FT_XON];
        xoff_en     = en[FT_XOFF];
        flow_ctl_on = xon_en || xoff_en;

        // transmit sequencing: one character on the line at a time
        data_ok   = !fifo_empty && !(st_q.flow == FL_HALTPEND || st_q.flow == FL_HALTED);
        load_x    = !st_q.busy && (st_q.pend != PD_NONE);
        load_data = !st_q.busy && !load_x && data_ok;
        ser_load  = load_x || load_data;
        fifo_pop  = load_data;
        ser_data  = load_x ? ((st_q.pend == PD_XON) ? st_q.xon_chr : st_q.xoff_chr) : fifo_data;
        busy_now  = (st_q.busy && !ser_done) || ser_load;

        charst = 2'b00;
        if (st_q.auto_rx || flow_ctl_on)
            charst = (st_q.pend != PD_NONE) ? st_q.pend : {1'b0, st_q.idle_wait};
        stat = {st_q.rxx, st_q.atx, st_q.flow, charst};

        st_d = st_q;

        // line occupancy and idle-wait tracking
        if (ser_load)      st_d.busy = 1'b1;
        else if (ser_done) st_d.busy = 1'b0;
        if (ser_load) st_d.cur_x = load_x;
        if (ser_load)                     st_d.idle_wait = 1'b0;
        else if (ser_done && st_q.cur_x)  st_d.idle_wait = 1'b1;

        // received flow characters: sticky, new events beat the read clear
        st_d.rxx = (rd_stat ? 2'b00 : st_q.rxx) | {hit_xon, hit_xoff};

        // send requests
        if (load_x) st_d.pend = PD_NONE;
        if (wr_cmd) begin
            if (reg_wdata[1])      st_d.pend = PD_XOFF;
            else if (reg_wdata[0]) st_d.pend = PD_XON;
        end
        if (!st_q.auto_rx) st_d.pend = PD_NONE;

        // flow characters sent
        st_d.atx = rd_stat ? 2'b00 : st_q.atx;
        if (load_x) begin
            if (st_q.pend == PD_XON) st_d.atx[0] = 1'b1;
            else                     st_d.atx[1] = 1'b1;
        end
        if (!st_q.auto_rx) st_d.atx = 2'b00;

        // transmit flow state
        if (xoff_en && hit_xoff && (st_q.flow == FL_NORMAL || st_q.flow == FL_REEN))
            st_d.flow = busy_now ? FL_HALTPEND : FL_HALTED;
        else if (xon_en && hit_xon && (st_q.flow == FL_HALTPEND || st_q.flow == FL_HALTED))
            st_d.flow = FL_REEN;
        else if (st_q.flow == FL_HALTPEND && ser_done)
            st_d.flow = FL_HALTED;
        else if (st_q.flow == FL_REEN && rd_stat)
            st_d.flow = FL_NORMAL;
        if (!flow_ctl_on) st_d.flow = FL_NORMAL;

        // host registers
        if (wr_mode) st_d.auto_rx  = reg_wdata[0];
        if (wr_xon)  st_d.xon_chr  = reg_wdata;
        if (wr_xoff) st_d.xoff_chr = reg_wdata;

        if (reg_rd) begin
            st_d.rdata = '0;
            case (reg_addr)
                ADR_STAT: st_d.rdata[7:0] = stat;
                ADR_ENAB: st_d.rdata[NFEAT-1:0] = en;
                ADR_MODE: st_d.rdata[0] = st_q.auto_rx;
                ADR_XON:  st_d.rdata = st_q.xon_chr;
                ADR_XOFF: st_d.rdata = st_q.xoff_chr;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.flow     <= FL_NORMAL;
            st_q.pend     <= PD_NONE;
            st_q.xon_chr  <= CHAR_W'(XON_RST);
            st_q.xoff_chr <= CHAR_W'(XOFF_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata   = st_q.rdata;
    assign wdog_en     = en[FT_WDOG];
    assign addr_rec_en = en[FT_ADDR];

    // R5
    no_pop_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !(st_q.flow == FL_HALTPEND || st_q.flow == FL_HALTED));
    // R3
    rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rxx != 2'b00 && !rd_stat) |=> (st_q.rxx != 2'b00));
    // R9
    atx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.auto_rx && $past(!st_q.auto_rx)) |-> (st_q.atx == 2'b00));
    // R6
    reen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && st_q.flow == FL_REEN && !(xoff_en && hit_xoff)) |=> (st_q.flow == FL_NORMAL));
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flow == FL_HALTED && xoff_en && !hit_xon && !wr_enab) |=> (st_q.flow == FL_HALTED));
endmodule

// File: tb/xflow_ctrl_bench.sv
module xflow_ctrl_bench;
    localparam int CHAR_CYC = 12;
    localparam int WDOG_LIM = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data = 8'd0;
    logic       fifo_pop, ser_load, ser_done = 1'b0;
    logic [7:0] ser_data;
    logic       wdog_en, addr_rec_en;

    int tests = 0, fails = 0, cyc = 0;
    byte unsigned fifo_q[$];
    byte unsigned sent_q[$];
    int  busy_cnt = 0;
    bit  pop_pend = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    xflow_ctrl u_xflow_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .ser_load(ser_load),
        .ser_data(ser_data), .ser_done(ser_done), .wdog_en(wdog_en),
        .addr_rec_en(addr_rec_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // FIFO and serializer models, stepped every clock away from the edge
    always @(negedge clk) begin
        #1;
        if (pop_pend && fifo_q.size() > 0) void'(fifo_q.pop_front());
        pop_pend   = 0;
        fifo_empty = (fifo_q.size() == 0);
        fifo_data  = fifo_empty ? 8'h00 : fifo_q[0];
        ser_done   = 1'b0;
        if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) ser_done = 1'b1;
        end
        #1;
        if (rst_n && ser_load) begin
            tests++;
            if (busy_cnt != 0 || ser_done) begin
                fails++;
                $display("FAIL R8 overlap actual=%0d expected=0", busy_cnt);
            end
            if (fifo_pop && ser_data != fifo_data) begin
                fails++;
                $display("FAIL R8 data actual=%0h expected=%0h", ser_data, fifo_data);
            end
            sent_q.push_back(ser_data);
            busy_cnt = CHAR_CYC;
            if (fifo_pop) pop_pend = 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIM && !finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG_LIM);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        v = reg_rdata;
    endtask

    task automatic rx(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1; rx_data = c;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk);
        fifo_q.push_back(c);
    endtask

    initial begin
        logic [7:0] v;
        int n0;
        idle(3);
        rst_n = 1;
        idle(2);

        // R1 reset state
        rd(3'd0, v); chk("R1 status", v, 8'h00);
        rd(3'd1, v); chk("R1 enables", v, 8'h00);
        rd(3'd2, v); chk("R1 mode", v, 8'h00);
        rd(3'd3, v); chk("R1 xon char", v, 8'h11);
        rd(3'd4, v); chk("R1 xoff char", v, 8'h13);

        // R2 set/clear pairs
        wr(3'd1, 8'b0000_0101);
        rd(3'd1, v); chk("R2 set wd+addr", v, 8'h03);
        chk("R2 wdog_en pin", wdog_en, 1);
        chk("R2 addr_rec_en pin", addr_rec_en, 1);
        wr(3'd1, 8'b0000_0011);
        rd(3'd1, v); chk("R2 both bits clear", v, 8'h02);
        wr(3'd1, 8'h00);
        rd(3'd1, v); chk("R2 zeros hold", v, 8'h02);
        wr(3'd1, 8'b0000_1000);
        chk("R2 addr cleared", addr_rec_en, 0);

        // R3 detection with everything disabled
        rx(8'h13);
        rd(3'd0, v); chk("R3 xoff seen", v[7:6], 2'b01);
        rd(3'd0, v); chk("R4 cleared", v[7:6], 2'b00);
        rx(8'h11); rx(8'h41); rx(8'h13);
        rd(3'd0, v); chk("R3 both seen", v[7:6], 2'b11);
        rx(8'h41);
        rd(3'd0, v); chk("R3 no match", v[7:6], 2'b00);

        // R4 event in the same cycle as the read
        @(negedge clk);
        reg_rd = 1; reg_addr = 3'd0; rx_valid = 1; rx_data = 8'h13;
        @(negedge clk);
        reg_rd = 0; rx_valid = 0;
        chk("R4 read before event", reg_rdata[7:6], 2'b00);
        rd(3'd0, v); chk("R4 event kept", v[7:6], 2'b01);

        // R7 recognitions off: Xoff ignored by transmitter
        n0 = sent_q.size();
        rx(8'h13);
        push(8'h41); push(8'h42);
        idle(3 * (CHAR_CYC + 2));
        chk("R7 data sent", sent_q.size() - n0, 2);
        rd(3'd0, v); chk("R7 flow normal", v[3:2], 2'b00);

        // R5 immediate halt, R6 resume
        wr(3'd1, 8'b0101_0000);
        rx(8'h13);
        rd(3'd0, v); chk("R5 halted idle", v[3:2], 2'b11);
        n0 = sent_q.size();
        push(8'h43); push(8'h44);
        idle(2 * (CHAR_CYC + 2));
        chk("R5 nothing sent", sent_q.size() - n0, 0);
        rx(8'h11);
        rd(3'd0, v); chk("R6 re-enabled", v[3:2], 2'b10);
        idle(3 * (CHAR_CYC + 2));
        chk("R6 data resumed", sent_q.size() - n0, 2);
        rd(3'd0, v); chk("R6 back to normal", v[3:2], 2'b00);

        // R5 halt pending while a character is on the line
        n0 = sent_q.size();
        push(8'h45); push(8'h46); push(8'h47);
        idle(3);
        rx(8'h13);
        rd(3'd0, v); chk("R5 halt pending", v[3:2], 2'b01);
        idle(CHAR_CYC + 4);
        rd(3'd0, v); chk("R5 halted after done", v[3:2], 2'b11);
        chk("R5 one char finished", sent_q.size() - n0, 1);
        rx(8'h11);
        idle(3 * (CHAR_CYC + 2));
        chk("R6 rest sent", sent_q.size() - n0, 3);
        rd(3'd0, v); rd(3'd0, v);

        // R8 insertion ahead of FIFO data
        wr(3'd2, 8'h01);
        rd(3'd2, v); chk("R8 mode readback", v, 8'h01);
        n0 = sent_q.size();
        push(8'h48); push(8'h49);
        idle(2);
        wr(3'd5, 8'h01);
        rd(3'd0, v); chk("R10 xon pending", v[1:0], 2'b11);
        idle(3 * (CHAR_CYC + 2));
        chk("R8 count", sent_q.size() - n0, 3);
        chk("R8 order 0", sent_q[n0], 8'h48);
        chk("R8 order 1", sent_q[n0 + 1], 8'h11);
        chk("R8 order 2", sent_q[n0 + 2], 8'h49);
        rd(3'd0, v);
        chk("R9 xon sent", v[5:4], 2'b01);
        chk("R10 normal after data", v[1:0], 2'b00);
        wr(3'd5, 8'h03);
        idle(CHAR_CYC + 4);
        chk("R8 xoff wins", sent_q[sent_q.size() - 1], 8'h13);
        rd(3'd0, v);
        chk("R9 xoff sent", v[5:4], 2'b10);
        chk("R10 idle wait", v[1:0], 2'b01);

        // R8 send while halted
        rx(8'h13);
        n0 = sent_q.size();
        push(8'h4A);
        wr(3'd5, 8'h01);
        idle(2 * (CHAR_CYC + 2));
        chk("R8 halted only X", sent_q.size() - n0, 1);
        chk("R8 halted X char", sent_q[n0], 8'h11);
        rd(3'd0, v);
        chk("R5 still halted", v[3:2], 2'b11);
        chk("R10 idle wait halted", v[1:0], 2'b01);
        rx(8'h11);
        idle(CHAR_CYC + 4);
        chk("R6 queued data", sent_q[sent_q.size() - 1], 8'h4A);
        rd(3'd0, v); rd(3'd0, v);

        // R9 field cleared when auto mode goes off, R8 commands ignored
        wr(3'd5, 8'h01);
        idle(CHAR_CYC + 4);
        wr(3'd2, 8'h00);
        rd(3'd0, v); chk("R9 off clears", v[5:4], 2'b00);
        n0 = sent_q.size();
        wr(3'd5, 8'h02);
        idle(CHAR_CYC + 4);
        chk("R8 ignored when off", sent_q.size() - n0, 0);
        rd(3'd0, v); chk("R10 idle wait flow on", v[1:0], 2'b01);
        wr(3'd1, 8'b1010_0000);
        rd(3'd0, v); chk("R10 forced zero", v[1:0], 2'b00);

        // R11 programmable match characters
        wr(3'd3, 8'hA5);
        rd(3'd3, v); chk("R11 readback", v, 8'hA5);
        rd(3'd0, v);
        rx(8'hA5);
        rd(3'd0, v); chk("R11 new pattern", v[7:6], 2'b10);
        rx(8'h11);
        rd(3'd0, v); chk("R11 old pattern", v[7:6], 2'b00);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule